// File: doc/BRIEF.md
# MSK Frame Detector And Receive Buffer

This block sits behind an MSK demodulator and works on the recovered bit stream. Each demodulated bit arrives with a one-cycle strobe that marks the recovered bit clock. While the frame-enable bit is clear, the block watches the stream for a programmable 16-bit sync word. When the word matches, it raises a frame indication that lasts one bit period, and it arms itself for data. From then on, every eight received bits are packed into a byte and placed in a one-byte buffer.

A single active-low status output serves two uses, chosen by a select input. In frame mode it carries the sync pulse. In byte mode it carries a byte-ready flag. The host reads the buffered byte by toggling a serial clock eight times, and one bit leaves on each falling edge. The frame-enable bit lives inside the block, because the block sets it on its own when it detects a frame. The host ends a reception by raising its direction line and writing 0 to the frame-enable bit. This refills the bit history with ones and restarts the search. If the host sets frame enable to 1 from the start, no sync search runs and bytes flow continuously.

Top module: `msk_fd_rxbuf`

## Requirements
- R1: The sync word is `{pat_hi_i, pat_lo_i}`. The first bit received in the window is compared against `pat_hi_i[7]` and the last against `pat_lo_i[0]`. A match is taken only on the strobe that completes the word, and only while `frame_en_o` is 0.
- R2: With `stat_sel_i`=0 (frame mode), `rx_stat_no` goes low in the cycle after the matching strobe. It returns high in the cycle after the next bit strobe, so the pulse lasts one bit period.
- R3: A match sets `frame_en_o` to 1 in the following cycle, and the sync search stops.
- R4: A write of 0 to frame enable (`fe_wr_i`=1, `fe_wdata_i`=0) is ignored while the frame pulse is active. The same write is accepted once the pulse has ended.
- R5: While `frame_en_o` is 1, every eight bit strobes form one byte, counted from the first strobe after the match. With `stat_sel_i`=1 (byte mode), `rx_stat_no` goes low in the cycle after the eighth strobe.
- R6: While a byte is ready, each falling edge of `host_sclk_i` puts the next bit on `host_sdo_o`, registered one cycle after the edge is seen. The first-received bit comes out first. Falling edges while no byte is ready leave `host_sdo_o` unchanged.
- R7: The byte-ready flag clears after the eighth falling edge, and `rx_stat_no` (byte mode) then returns high.
- R8: If a new byte completes before the previous one has been fully read, the new byte replaces the buffer and the flag stays low. This holds even when the byte completes in the same cycle as the eighth falling edge of a read.
- R9: An accepted write of 0 to frame enable while `host_dir_i` is 1 clears the byte-ready flag and the frame pulse. It also fills the 16-bit bit history with ones and clears the byte counter, so the next search starts from all ones.
- R10: Writing frame enable to 1 with `stat_sel_i`=1 delivers bytes continuously, with no sync word needed.
- R11: After reset, `rx_stat_no`=1, `host_sdo_o`=1 and `frame_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe per recovered bit |
| bit_i | input | 1 | Demodulated bit, valid with the strobe |
| pat_lo_i | input | 8 | Low byte of the sync word |
| pat_hi_i | input | 8 | High byte of the sync word (received first) |
| fe_wr_i | input | 1 | Write strobe for the frame-enable bit |
| fe_wdata_i | input | 1 | Value written to frame enable (0 = search) |
| stat_sel_i | input | 1 | Status select: 0 frame pulse, 1 byte ready |
| host_dir_i | input | 1 | Host direction line; high while ending reception |
| host_sclk_i | input | 1 | Host serial read clock |
| host_sdo_o | output | 1 | Serial read data |
| rx_stat_no | output | 1 | Active-low status: frame pulse or byte ready |
| frame_en_o | output | 1 | Current frame-enable bit |

## Verification
Two functions can act on the buffer in the same cycle: the completion of a new byte and the eighth falling edge of a host read. The bench first reads seven bits of one byte. It then drives the last bit strobe of the next byte and the final falling clock edge in one cycle. The check passes if the flag stays low and the next full read returns the new byte. A second overlap comes from a write of 0 to frame enable that lands while the frame pulse is active. That case is judged by `frame_en_o` staying 1 until the pulse has ended.

// File: rtl/msk_fd_pkg.sv
package msk_fd_pkg;
  typedef enum logic {
    STAT_FRAME = 1'b0,
    STAT_BYTE  = 1'b1
  } stat_sel_e;
endpackage

// File: rtl/msk_sync_search.sv
module msk_sync_search #(
  parameter int PAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             bit_i,
  input  logic             search_i,
  input  logic             restart_i,
  input  logic [PAT_W-1:0] pattern_i,
  output logic             match_o
);
  logic [PAT_W-1:0] hist_q;
  logic [PAT_W-1:0] hist_nxt;

  // oldest bit ends up at the MSB
  assign hist_nxt = {hist_q[PAT_W-2:0], bit_i};
  assign match_o  = bit_stb_i && search_i && (hist_nxt == pattern_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '1;
    else if (restart_i) hist_q <= '1;
    else if (bit_stb_i) hist_q <= hist_nxt;
  end
endmodule

// File: rtl/msk_byte_asm.sv
module msk_byte_asm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic              run_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] asm_q;

  assign byte_o      = {asm_q[BYTE_W-2:0], bit_i};
  assign byte_done_o = run_i && bit_stb_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      asm_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (bit_stb_i) begin
      asm_q <= byte_o;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/msk_host_read.sv
module msk_host_read #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              clear_i,
  input  logic              sclk_i,
  output logic              ready_o,
  output logic              sdo_o,
  output logic              fall_o,
  output logic              last_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic              sclk_q;
  logic              ready_q;
  logic              sdo_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] buf_q;

  assign fall_o  = sclk_q && !sclk_i;
  assign last_o  = fall_o && ready_q && (cnt_q == LAST);
  assign ready_o = ready_q;
  assign sdo_o   = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      sdo_q   <= 1'b1;
      cnt_q   <= '0;
      buf_q   <= '0;
    end else if (clear_i) begin
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      // new byte wins over a read in progress
      buf_q   <= load_data_i;
      ready_q <= 1'b1;
      cnt_q   <= '0;
    end else if (fall_o && ready_q) begin
      sdo_q <= buf_q[BYTE_W-1];
      buf_q <= {buf_q[BYTE_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) ready_q <= 1'b0;
    end
  end
endmodule

// File: rtl/msk_fd_rxbuf.sv
module msk_fd_rxbuf
  import msk_fd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic [BYTE_W-1:0] pat_lo_i,
  input  logic [BYTE_W-1:0] pat_hi_i,
  input  logic              fe_wr_i,
  input  logic              fe_wdata_i,
  input  logic              stat_sel_i,
  input  logic              host_dir_i,
  input  logic              host_sclk_i,
  output logic              host_sdo_o,
  output logic              rx_stat_no,
  output logic              frame_en_o
);
  localparam int PAT_W = 2 * BYTE_W;

  logic              frame_en_q;
  logic              fd_pulse_q;
  logic              match;
  logic              wr_ok;
  logic              restart;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              ready;
  logic              sclk_fall;
  logic              read_last;

  // a clear is blocked while the frame pulse is shown
  assign wr_ok   = fe_wr_i && !(fd_pulse_q && !fe_wdata_i);
  assign restart = wr_ok && !fe_wdata_i && host_dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_en_q <= 1'b0;
    else if (match) frame_en_q <= 1'b1;
    else if (wr_ok) frame_en_q <= fe_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fd_pulse_q <= 1'b0;
    else if (restart)   fd_pulse_q <= 1'b0;
    else if (match)     fd_pulse_q <= 1'b1;
    else if (bit_stb_i) fd_pulse_q <= 1'b0;
  end

  msk_sync_search #(.PAT_W(PAT_W)) u_search (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_stb_i (bit_stb_i),
    .bit_i     (bit_i),
    .search_i  (!frame_en_q),
    .restart_i (restart),
    .pattern_i ({pat_hi_i, pat_lo_i}),
    .match_o   (match)
  );

  msk_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_stb_i   (bit_stb_i),
    .bit_i       (bit_i),
    .run_i       (frame_en_q),
    .byte_done_o (byte_done),
    .byte_o      (byte_val)
  );

  msk_host_read #(.BYTE_W(BYTE_W)) u_read (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (byte_done),
    .load_data_i (byte_val),
    .clear_i     (restart),
    .sclk_i      (host_sclk_i),
    .ready_o     (ready),
    .sdo_o       (host_sdo_o),
    .fall_o      (sclk_fall),
    .last_o      (read_last)
  );

  assign rx_stat_no = (stat_sel_e'(stat_sel_i) == STAT_BYTE) ? !ready : !fd_pulse_q;
  assign frame_en_o = frame_en_q;
endmodule

// File: rtl/msk_fd_rxbuf_chk.sv
module msk_fd_rxbuf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_stb_i,
  input logic fe_wr_i,
  input logic fe_wdata_i,
  input logic match,
  input logic frame_en_q,
  input logic fd_pulse_q,
  input logic restart,
  input logic byte_done,
  input logic ready,
  input logic read_last,
  input logic sclk_fall,
  input logic host_sdo_o
);
  AST_MATCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> fd_pulse_q); // R2
  AST_PULSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fd_pulse_q && bit_stb_i && !match) |=> !fd_pulse_q); // R2
  AST_MATCH_SETS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> frame_en_q); // R3
  AST_CLEAR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fd_pulse_q && fe_wr_i && !fe_wdata_i) |=> frame_en_q); // R4
  AST_BYTE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !restart) |=> ready); // R5
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(host_sdo_o)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_last && !byte_done && !restart) |=> !ready); // R7
  AST_OVERWRITE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && byte_done && read_last && !restart) |=> ready); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (!ready && !fd_pulse_q && !frame_en_q)); // R9
endmodule

bind msk_fd_rxbuf msk_fd_rxbuf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_stb_i  (bit_stb_i),
  .fe_wr_i    (fe_wr_i),
  .fe_wdata_i (fe_wdata_i),
  .match      (match),
  .frame_en_q (frame_en_q),
  .fd_pulse_q (fd_pulse_q),
  .restart    (restart),
  .byte_done  (byte_done),
  .ready      (ready),
  .read_last  (read_last),
  .sclk_fall  (sclk_fall),
  .host_sdo_o (host_sdo_o)
);

// File: tb/tb_msk_fd_rxbuf.sv
`timescale 1ns/1ps
module tb_msk_fd_rxbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, bit_v = 1'b0;
  logic [7:0] pat_lo = 8'hC3, pat_hi = 8'hA5;
  logic fe_wr = 1'b0, fe_wdata = 1'b0;
  logic stat_sel = 1'b0, host_dir = 1'b0, host_sclk = 1'b1;
  logic host_sdo, rx_stat_n, frame_en;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  msk_fd_rxbuf dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(bit_stb), .bit_i(bit_v),
    .pat_lo_i(pat_lo), .pat_hi_i(pat_hi), .fe_wr_i(fe_wr), .fe_wdata_i(fe_wdata),
    .stat_sel_i(stat_sel), .host_dir_i(host_dir), .host_sclk_i(host_sclk),
    .host_sdo_o(host_sdo), .rx_stat_no(rx_stat_n), .frame_en_o(frame_en)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_stb = 1'b1; bit_v = b;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
  endtask

  // driver: bits msb first from index hi down to lo
  task automatic send_bits(input logic [15:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(v[i]);
  endtask

  task automatic write_fe(input logic d);
    fe_wr = 1'b1; fe_wdata = d;
    @(negedge clk); fe_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_bits(input int n, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      host_sclk = 1'b0;
      @(negedge clk); v = {v[6:0], host_sdo};
      host_sclk = 1'b1;
      @(negedge clk);
    end
  endtask

  // monitor: pops the expected byte and compares a full read
  task automatic read_check(input string tag);
    logic [7:0] got, exp;
    exp = exp_q.pop_front();
    read_bits(8, got);
    check(got == exp, tag, got, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] tmp;
    repeat (3) @(negedge clk);
    check(rx_stat_n == 1'b1, "R11 status after reset", {7'd0, rx_stat_n}, 8'd1);
    check(host_sdo == 1'b1, "R11 sdo after reset", {7'd0, host_sdo}, 8'd1);
    check(frame_en == 1'b0, "R11 frame_en after reset", {7'd0, frame_en}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // sync search, frame mode
    send_bits(16'h0000, 3, 0);
    send_bits(16'hA5C3, 15, 1);
    check(rx_stat_n == 1'b1, "R1 no match before last bit", {7'd0, rx_stat_n}, 8'd1);
    send_bit(1'b1);
    check(rx_stat_n == 1'b0, "R2 frame pulse low", {7'd0, rx_stat_n}, 8'd0);
    check(frame_en == 1'b1, "R3 frame_en set on match", {7'd0, frame_en}, 8'd1);
    write_fe(1'b0);
    check(frame_en == 1'b1, "R4 clear ignored during pulse", {7'd0, frame_en}, 8'd1);
    check(rx_stat_n == 1'b0, "R2 pulse held until next strobe", {7'd0, rx_stat_n}, 8'd0);

    // first data byte 0x3C; its first bit ends the pulse
    exp_q.push_back(8'h3C);
    send_bit(1'b0);
    check(rx_stat_n == 1'b1, "R2 pulse ends after one bit", {7'd0, rx_stat_n}, 8'd1);
    stat_sel = 1'b1;
    send_bits(16'h003C, 6, 1);
    check(rx_stat_n == 1'b1, "R5 not ready after 7 bits", {7'd0, rx_stat_n}, 8'd1);
    send_bit(1'b0);
    check(rx_stat_n == 1'b0, "R5 ready after 8 bits", {7'd0, rx_stat_n}, 8'd0);
    read_check("R6 read byte 0x3C");
    check(rx_stat_n == 1'b1, "R7 flag cleared after read", {7'd0, rx_stat_n}, 8'd1);

    // overwrite
    send_bits(16'h0011, 7, 0);
    exp_q.push_back(8'hE7);
    send_bits(16'h00E7, 7, 0);
    check(rx_stat_n == 1'b0, "R8 flag low after overwrite", {7'd0, rx_stat_n}, 8'd0);
    read_check("R8 newest byte read");
    check(rx_stat_n == 1'b1, "R7 flag cleared after second read", {7'd0, rx_stat_n}, 8'd1);
    read_bits(1, tmp);
    check(host_sdo == 1'b1, "R6 sdo unchanged when not ready", {7'd0, host_sdo}, 8'd1);

    // collision: 8th fall and byte completion in one cycle
    exp_q.push_back(8'h5A);
    send_bits(16'h005A, 7, 0);
    read_bits(7, tmp);
    void'(exp_q.pop_front());
    check(tmp == 8'h2D, "R6 partial read 7 bits", tmp, 8'h2D);
    exp_q.push_back(8'h96);
    send_bits(16'h0096, 7, 1);
    bit_stb = 1'b1; bit_v = 1'b0; host_sclk = 1'b0;
    @(negedge clk); bit_stb = 1'b0; host_sclk = 1'b1;
    @(negedge clk);
    check(rx_stat_n == 1'b0, "R8 flag stays low on collision", {7'd0, rx_stat_n}, 8'd0);
    read_check("R8 collision byte 0x96");

    // restart with direction high
    send_bits(16'h0000, 7, 0);
    check(rx_stat_n == 1'b0, "R5 byte before restart", {7'd0, rx_stat_n}, 8'd0);
    host_dir = 1'b1;
    write_fe(1'b0);
    host_dir = 1'b0;
    check(rx_stat_n == 1'b1, "R9 restart clears ready", {7'd0, rx_stat_n}, 8'd1);
    check(frame_en == 1'b0, "R9 search re-enabled", {7'd0, frame_en}, 8'd0);
    pat_hi = 8'hFF; pat_lo = 8'hF0; stat_sel = 1'b0;
    send_bits(16'h0000, 2, 0);
    check(rx_stat_n == 1'b1, "R9 no match after 3 zeros", {7'd0, rx_stat_n}, 8'd1);
    send_bit(1'b0);
    check(rx_stat_n == 1'b0, "R9 history filled with ones", {7'd0, rx_stat_n}, 8'd0);
    send_bit(1'b1);
    write_fe(1'b0);
    check(frame_en == 1'b0, "R4 clear accepted after pulse", {7'd0, frame_en}, 8'd0);

    // continuous mode
    write_fe(1'b1);
    stat_sel = 1'b1;
    exp_q.push_back(8'hC8);
    send_bits(16'h00C8, 7, 0);
    check(rx_stat_n == 1'b0, "R10 byte without sync", {7'd0, rx_stat_n}, 8'd0);
    read_check("R10 continuous byte 0xC8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule